// File: doc/BRIEF.md
# Shared-Clock Timer Bank

This block holds many independent delay timers (on-delay, off-delay and pulse) without giving any of them a counter of its own. One free-running millisecond time base serves every instance. Each instance keeps only its stored trigger level, preset, kind, start timestamp and one pulse-state bit in small per-instance storage. A single address selects one instance per cycle. Shared subtract-and-compare logic then derives that instance's elapsed time and status combinationally within the same cycle.

There are no edge detectors. The start cell of the addressed instance is rewritten with the current time base on every access while the instance is idle. That write is withheld once the instance is triggered, so the timestamp freezes at the trigger access. An instance that is not addressed is never touched. Its stored timestamp still yields the exact elapsed time whenever it is next read. The flip-flop count of the evaluation path is therefore independent of the number of instances.

Kind encoding: 0 = on-delay, 1 = off-delay, 2 = pulse, 3 = behaves as on-delay.

Top module: `tmr_bank`

## Requirements
- R1: `rtc_ms` is 0 after reset and advances by exactly one after every TICK_DIV rising clock edges. After k edges it reads floor(k / TICK_DIV), wrapping modulo 2^TW.
- R2: After reset every instance is kind 0 with stored trigger low, preset 0 and pulse bit clear, so every address reads `q`=0 and `et`=0.
- R3: On-delay with effective trigger low: `q`=0 and `et`=0, and the start cell is rewritten with `rtc_ms` on each access whose stored trigger was low.
- R4: On-delay with effective trigger high: the start freezes at the `rtc_ms` of the access where the stored trigger went from low to high. `et` is min(rtc-start, preset) and `q` is 1 exactly when rtc-start >= preset.
- R5: Off-delay: while the trigger is high, `q`=1 and `et`=0. The start is captured at the access where the stored trigger falls. After that, `q` stays 1 while rtc-start < preset, and `et` is min(rtc-start, preset).
- R6: Pulse: a high trigger with no pulse running starts a pulse at that access. During the pulse, `q` = (rtc-start < preset) regardless of later trigger changes. The pulse state ends only once the trigger is low and time has reached the preset. `et` is 0 while no pulse is held.
- R7: `et` never exceeds the effective preset of the addressed instance.
- R8: Trigger and preset writes act on the outputs in the cycle they are presented. A kind write takes effect from the next cycle and clears the pulse bit.
- R9: An instance's stored state changes only in cycles where it is addressed. A timer started and then left unaddressed reports the exact elapsed time when it is read again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_addr | input | AW | Addressed instance |
| in_we | input | 1 | Write trigger level of addressed instance |
| in_val | input | 1 | Trigger level to write |
| pt_we | input | 1 | Write preset of addressed instance |
| pt_val | input | TW | Preset in ticks |
| kind_we | input | 1 | Write kind of addressed instance |
| kind_val | input | 2 | Kind code (0 on, 1 off, 2 pulse) |
| q | output | 1 | Status of addressed instance |
| et | output | TW | Elapsed ticks of addressed instance |
| rtc_ms | output | TW | Shared time base |

## Verification
A start cell that is captured one access late or early shows as an `et` offset on the very next read of that instance. The offset persists until the instance is retriggered, so the elapsed-time comparison on every random access exposes it at once. A pulse bit that clears too early lets a pulse retrigger while the trigger is still high, and `q` rises where the model holds it low. A stray write to an unaddressed instance surfaces only when that instance is next selected. For that reason the stimulus returns repeatedly to a small set of addresses and also parks a timer through long stretches of other traffic.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    TK_ON    = 2'd0,
    TK_OFF   = 2'd1,
    TK_PULSE = 2'd2,
    TK_RSV   = 2'd3
  } tkind_e;
endpackage

// File: rtl/tmr_rtc.sv
module tmr_rtc #(
  parameter int TW       = 32,
  parameter int TICK_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] rtc
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] pre_q, pre_d;
  logic [TW-1:0] rtc_q, rtc_d;
  logic          tick;

  always_comb begin
    tick  = (pre_q == PW'(TICK_DIV - 1));
    pre_d = tick ? '0 : pre_q + 1'b1;
    rtc_d = tick ? rtc_q + 1'b1 : rtc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      rtc_q <= '0;
    end else begin
      pre_q <= pre_d;
      rtc_q <= rtc_d;
    end
  end

  assign rtc = rtc_q;

  // R1: time base steps by one on a tick and holds otherwise
  p_rtc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (rtc_q == $past(rtc_q) + 1'b1));
  p_rtc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(rtc_q));
endmodule

// File: rtl/tmr_store.sv
module tmr_store
  import tmr_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 4,
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          in_we,
  input  logic          in_d,
  input  logic          pt_we,
  input  logic [TW-1:0] pt_d,
  input  logic          kind_we,
  input  tkind_e        kind_d,
  input  logic          st_we,
  input  logic [TW-1:0] st_d,
  input  logic          bit_d,
  output logic          rd_in,
  output logic [TW-1:0] rd_pt,
  output tkind_e        rd_kind,
  output logic [TW-1:0] rd_st,
  output logic          rd_bit
);
  logic          in_m   [N];
  logic          bit_m  [N];
  tkind_e        kind_m [N];
  logic [TW-1:0] pt_m   [N];
  logic [TW-1:0] st_m   [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic sel;
    assign sel = (addr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_m[i]   <= 1'b0;
        bit_m[i]  <= 1'b0;
        kind_m[i] <= TK_ON;
        pt_m[i]   <= '0;
        st_m[i]   <= '0;
      end else if (sel) begin
        if (in_we)   in_m[i]   <= in_d;
        if (pt_we)   pt_m[i]   <= pt_d;
        if (kind_we) kind_m[i] <= kind_d;
        if (st_we)   st_m[i]   <= st_d;
        bit_m[i] <= bit_d;
      end
    end
  end

  always_comb begin
    rd_in   = in_m[addr];
    rd_pt   = pt_m[addr];
    rd_kind = kind_m[addr];
    rd_st   = st_m[addr];
    rd_bit  = bit_m[addr];
  end
endmodule

// File: rtl/tmr_eval.sv
module tmr_eval
  import tmr_pkg::*;
#(
  parameter int TW = 32
) (
  input  tkind_e        kind,
  input  logic          in_s,
  input  logic          in_eff,
  input  logic          bit_s,
  input  logic [TW-1:0] start_s,
  input  logic [TW-1:0] pt,
  input  logic [TW-1:0] rtc,
  output logic          cap,
  output logic          bit_next,
  output logic          q,
  output logic [TW-1:0] et
);
  logic          is_off, is_pulse, live, done_old, done, gate;
  logic [TW-1:0] start_eff, raw;

  always_comb begin
    is_off    = (kind == TK_OFF);
    is_pulse  = (kind == TK_PULSE);
    // pulse state as of the last access, ended if trigger low and time up
    done_old  = ((rtc - start_s) >= pt);
    live      = bit_s & ~(~in_s & done_old);
    if (is_pulse)    cap = ~live;
    else if (is_off) cap = in_s;
    else             cap = ~in_s;
    start_eff = cap ? rtc : start_s;
    raw       = rtc - start_eff;
    done      = (raw >= pt);
    bit_next  = is_pulse & (live | in_eff);
    if (is_pulse) begin
      q    = bit_next & ~done;
      gate = bit_next;
    end else if (is_off) begin
      q    = in_eff | ~done;
      gate = ~in_eff;
    end else begin
      q    = in_eff & done;
      gate = in_eff;
    end
    et = gate ? (done ? pt : raw) : '0;
  end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int N        = 16,
  parameter int TW       = 32,
  parameter int TICK_DIV = 4,
  localparam int AW      = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] sel_addr,
  input  logic          in_we,
  input  logic          in_val,
  input  logic          pt_we,
  input  logic [TW-1:0] pt_val,
  input  logic          kind_we,
  input  logic [1:0]    kind_val,
  output logic          q,
  output logic [TW-1:0] et,
  output logic [TW-1:0] rtc_ms
);
  logic          rd_in, rd_bit, cap, bit_next, in_eff, bit_wr;
  logic [TW-1:0] rd_pt, rd_st, pt_eff, rtc;
  tkind_e        rd_kind;

  tmr_rtc #(.TW(TW), .TICK_DIV(TICK_DIV)) u_rtc (
    .clk(clk), .rst_n(rst_n), .rtc(rtc)
  );

  tmr_store #(.N(N), .AW(AW), .TW(TW)) u_store (
    .clk(clk), .rst_n(rst_n), .addr(sel_addr),
    .in_we(in_we), .in_d(in_val),
    .pt_we(pt_we), .pt_d(pt_val),
    .kind_we(kind_we), .kind_d(tkind_e'(kind_val)),
    .st_we(cap), .st_d(rtc),
    .bit_d(bit_wr),
    .rd_in(rd_in), .rd_pt(rd_pt), .rd_kind(rd_kind),
    .rd_st(rd_st), .rd_bit(rd_bit)
  );

  always_comb begin
    in_eff = in_we ? in_val : rd_in;
    pt_eff = pt_we ? pt_val : rd_pt;
    bit_wr = kind_we ? 1'b0 : bit_next;
  end

  tmr_eval #(.TW(TW)) u_eval (
    .kind(rd_kind), .in_s(rd_in), .in_eff(in_eff), .bit_s(rd_bit),
    .start_s(rd_st), .pt(pt_eff), .rtc(rtc),
    .cap(cap), .bit_next(bit_next), .q(q), .et(et)
  );

  assign rtc_ms = rtc;

  // R3: idle on-delay reads zero and low
  p_ton_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_kind == TK_ON) && !in_eff) |-> (et == '0 && !q));
  // R4: an active on-delay output implies elapsed reached preset
  p_ton_q_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_kind == TK_ON) && q) |-> (et == pt_eff));
  // R5: off-delay with trigger high is on with zero elapsed
  p_tof_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_kind == TK_OFF) && in_eff) |-> (q && et == '0));
  // R6: a live pulse has elapsed below preset
  p_tp_q_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_kind == TK_PULSE) && q) |-> (et < pt_eff));
  // R7: elapsed is clamped to the preset
  p_et_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    et <= pt_eff);
endmodule

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb;
  localparam int N        = 16;
  localparam int TW       = 32;
  localparam int TICK_DIV = 4;
  localparam int AW       = 4;
  localparam time PERIOD  = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] sel_addr = '0;
  logic          in_we = 1'b0, in_val = 1'b0, pt_we = 1'b0, kind_we = 1'b0;
  logic [TW-1:0] pt_val = '0;
  logic [1:0]    kind_val = '0;
  logic          q;
  logic [TW-1:0] et, rtc_ms;

  int checks = 0;
  int errors = 0;
  int edges  = 0;
  bit finished = 1'b0;

  logic [1:0]    m_kind [N];
  bit            m_in   [N];
  bit            m_bit  [N];
  logic [TW-1:0] m_pt   [N];
  logic [TW-1:0] m_st   [N];

  tmr_bank #(.N(N), .TW(TW), .TICK_DIV(TICK_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_addr(sel_addr),
    .in_we(in_we), .in_val(in_val), .pt_we(pt_we), .pt_val(pt_val),
    .kind_we(kind_we), .kind_val(kind_val),
    .q(q), .et(et), .rtc_ms(rtc_ms)
  );

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) if (rst_n) edges++;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one access: drive at falling edge, compare, update model for the rising edge
  task automatic step(input int a, input bit wi, input bit iv, input bit wp,
                      input logic [TW-1:0] pv, input bit wk,
                      input logic [1:0] kv, input string tag_o);
    logic [TW-1:0] now, pte, ste, raw, raw_old, exp_et;
    bit ine, live, cap, bnext, exp_q, gate;
    string tag;
    @(negedge clk);
    sel_addr = AW'(a); in_we = wi; in_val = iv; pt_we = wp; pt_val = pv;
    kind_we = wk; kind_val = kv;
    #2;
    now = TW'(edges / TICK_DIV);
    ine = wi ? iv : m_in[a];
    pte = wp ? pv : m_pt[a];
    raw_old = now - m_st[a];
    if (m_kind[a] == 2'd2) begin
      live  = m_bit[a] && !(!m_in[a] && raw_old >= pte);
      cap   = !live;
      ste   = cap ? now : m_st[a];
      raw   = now - ste;
      bnext = live || ine;
      exp_q = bnext && (raw < pte);
      gate  = bnext;
      tag   = "R6";
    end else if (m_kind[a] == 2'd1) begin
      cap   = m_in[a];
      ste   = cap ? now : m_st[a];
      raw   = now - ste;
      bnext = 1'b0;
      exp_q = ine || (raw < pte);
      gate  = !ine;
      tag   = "R5";
    end else begin
      cap   = !m_in[a];
      ste   = cap ? now : m_st[a];
      raw   = now - ste;
      bnext = 1'b0;
      exp_q = ine && (raw >= pte);
      gate  = ine;
      tag   = ine ? "R4" : "R3";
    end
    exp_et = gate ? ((raw >= pte) ? pte : raw) : '0;
    if (tag_o != "") tag = tag_o;
    chk(rtc_ms == now, "R1", "rtc_ms", rtc_ms, now);
    chk(q == exp_q, tag, "q", q, exp_q);
    chk(et == exp_et, tag, "et", et, exp_et);
    chk(et <= pte, "R7", "et<=pt", et, pte);
    m_in[a] = ine;
    m_pt[a] = pte;
    m_st[a] = ste;
    m_bit[a] = wk ? 1'b0 : bnext;
    if (wk) m_kind[a] = kv;
  endtask

  task automatic rd(input int a, input string tag_o);
    step(a, 0, 0, 0, '0, 0, 2'd0, tag_o);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20231014);
    for (int i = 0; i < N; i++) begin
      m_kind[i] = 2'd0; m_in[i] = 1'b0; m_bit[i] = 1'b0;
      m_pt[i] = '0; m_st[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset state of every instance
    for (int i = 0; i < N; i++) rd(i, "R2");
    // R8: pulse kind takes effect next cycle, then trigger and preset same cycle
    step(1, 0, 0, 0, '0, 1, 2'd2, "R8");
    step(1, 1, 1, 1, 32'd10, 0, 2'd0, "R8");
    for (int i = 0; i < 12; i++) rd(1, "R6");
    step(1, 1, 0, 0, '0, 0, 2'd0, "R6");
    for (int i = 0; i < 40; i++) rd(1, "R6");
    // R4: zero preset fires in the trigger cycle
    step(3, 1, 1, 1, 32'd0, 0, 2'd0, "R4");
    // R9: start a timer, leave it, return later
    step(2, 1, 1, 1, 32'd40, 0, 2'd0, "R9");
    for (int i = 0; i < 100; i++) rd(5 + (i % 4), "R9");
    rd(2, "R9");
    for (int i = 0; i < 80; i++) rd(6, "R9");
    rd(2, "R9");
    // R5: off-delay fall and hold
    step(4, 0, 0, 0, '0, 1, 2'd1, "R5");
    step(4, 1, 1, 1, 32'd6, 0, 2'd0, "R5");
    step(4, 1, 0, 0, '0, 0, 2'd0, "R5");
    for (int i = 0; i < 30; i++) rd(4, "R5");
    // random mix
    for (int n = 0; n < 5000; n++) begin
      int a;
      bit wi, wp, wk;
      a  = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, N-1))
                                         : int'($urandom_range(0, 3));
      wi = ($urandom_range(0, 9) < 2);
      wp = ($urandom_range(0, 19) == 0);
      wk = ($urandom_range(0, 39) == 0);
      step(a, wi, 1'($urandom_range(0, 1)), wp, TW'($urandom_range(0, 25)),
           wk, 2'($urandom_range(0, 3)), "");
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule